// File: doc/BRIEF.md
# Serial Port Interrupt Enable and Status Controller

This block gathers the interrupt events of one serial port into a single interrupt line. Thirteen single-cycle event pulses come from the transmit path, the receive path and the modem-line logic. Each pulse sets its own bit in a sticky status register. Software clears a status bit by writing a one to it at the status address.

The enable mask is never written as a whole. A write to one address sets the mask bits marked with a one. A write to a second address clears the mask bits marked with a one. A third address returns the mask value. The interrupt output is the OR of status AND mask, taken through one register stage.

Software accesses the block through a simple register bus with a write strobe, an address, write data and read data. Read data is combinational from the address. The event sources (FIFO level compares, line error checks, the receive timeout counter, modem edge detectors) and the FIFOs sit outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask and the status are all zero, and `irq_o` is low.
- R2: A write to offset 0x08 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x0C clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Reading offset 0x10 returns the mask in bits 12:0. A write to 0x10, or to any address other than 0x08 and 0x0C, leaves the mask unchanged.
- R5: Event input bit i sets status bit i on the clock edge where it is high. The bits are assigned as follows: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem status change, 10 transmit trigger, 11 transmit nearly full, 12 transmit overflow. A status bit stays set after its event input goes low. Reading offset 0x14 returns the status in bits 12:0.
- R6: A write to offset 0x14 clears only the status bits whose write-data bit is 1. Writing 0x1FFF clears every status bit.
- R7: An event on a bit in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R8: `irq_o` equals the OR over all bits of (status AND mask) as they stood one cycle earlier. An event on a masked-off bit never raises it.
- R9: Read-data bits 31:13 are always zero. Write-data bits 31:13 have no effect. Reads of 0x08, 0x0C and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 13 | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Writes and events take effect on the clock edge that samples them. A mask or status readback is therefore correct 1 ns after that edge. `irq_o` moves one edge later than the status or mask change that causes it. The bench keeps a cycle-accurate model of all three values. It updates the expected interrupt from the model state before each edge and its mask and status after that edge. Every output is sampled 1 ns after a rising edge, so the check matches this one-cycle gap exactly. The bench sweeps each of the 13 sources through set, hold, clear and mask, then runs multi-bit patterns and same-cycle collisions.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   // Source index assignment; status and mask bit i belong to source i.
   typedef enum int unsigned {
      SRC_RX_TRIG    = 0,
      SRC_RX_EMPTY   = 1,
      SRC_RX_FULL    = 2,
      SRC_TX_EMPTY   = 3,
      SRC_TX_FULL    = 4,
      SRC_RX_OVF     = 5,
      SRC_FRAME_ERR  = 6,
      SRC_PARITY_ERR = 7,
      SRC_RX_TMO     = 8,
      SRC_MODEM_CHG  = 9,
      SRC_TX_TRIG    = 10,
      SRC_TX_NFULL   = 11,
      SRC_TX_OVF     = 12
   } uirq_src_e;

   localparam int unsigned UIRQ_NUM_SRC  = 13;
   localparam int unsigned UIRQ_DATA_W   = 32;
   localparam int unsigned UIRQ_ADDR_W   = 8;

   localparam int unsigned UIRQ_OFS_SET  = 'h08;
   localparam int unsigned UIRQ_OFS_CLR  = 'h0C;
   localparam int unsigned UIRQ_OFS_MASK = 'h10;
   localparam int unsigned UIRQ_OFS_STAT = 'h14;

   // Decoded write actions handed from the register interface to storage.
   typedef struct packed {
      logic set_mask;
      logic clr_mask;
      logic clr_stat;
   } uirq_wr_t;

endpackage

// File: rtl/uirq_regif.sv
module uirq_regif #(
   parameter int unsigned NUM_SRC  = uirq_pkg::UIRQ_NUM_SRC,
   parameter int unsigned DATA_W   = uirq_pkg::UIRQ_DATA_W,
   parameter int unsigned ADDR_W   = uirq_pkg::UIRQ_ADDR_W,
   parameter int unsigned OFS_SET  = uirq_pkg::UIRQ_OFS_SET,
   parameter int unsigned OFS_CLR  = uirq_pkg::UIRQ_OFS_CLR,
   parameter int unsigned OFS_MASK = uirq_pkg::UIRQ_OFS_MASK,
   parameter int unsigned OFS_STAT = uirq_pkg::UIRQ_OFS_STAT
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_SRC-1:0]   mask_q,
   input  logic [NUM_SRC-1:0]   stat_q,
   output uirq_pkg::uirq_wr_t   wr_act,
   output logic [NUM_SRC-1:0]   wr_bits,
   output logic [DATA_W-1:0]    rdata
);
   localparam logic [ADDR_W-1:0] A_SET  = OFS_SET[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CLR  = OFS_CLR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_MASK = OFS_MASK[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_STAT = OFS_STAT[ADDR_W-1:0];
   localparam int unsigned       PAD_W  = DATA_W - NUM_SRC;

   logic [NUM_SRC-1:0] rd_sel;

   assign wr_bits = wdata[NUM_SRC-1:0];

   always_comb begin
      wr_act          = '0;
      wr_act.set_mask = wr_en && (addr == A_SET);
      wr_act.clr_mask = wr_en && (addr == A_CLR);
      wr_act.clr_stat = wr_en && (addr == A_STAT);
   end

   always_comb begin
      if (addr == A_MASK)      rd_sel = mask_q;
      else if (addr == A_STAT) rd_sel = stat_q;
      else                     rd_sel = '0;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         logic unused_wr_hi;
         assign unused_wr_hi = |wdata[DATA_W-1:NUM_SRC];
         assign rdata        = {{PAD_W{1'b0}}, rd_sel};
      end else begin : g_full
         assign rdata = rd_sel;
      end
   endgenerate

endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
   parameter int unsigned NUM_SRC = uirq_pkg::UIRQ_NUM_SRC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic [NUM_SRC-1:0] bits,
   output logic [NUM_SRC-1:0] mask_q
);
   logic [NUM_SRC-1:0] set_v;
   logic [NUM_SRC-1:0] clr_v;

   assign set_v = set_en ? bits : '0;
   assign clr_v = clr_en ? bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q & ~clr_v) | set_v;
   end

endmodule

// File: rtl/uirq_sticky_stat.sv
module uirq_sticky_stat #(
   parameter int unsigned NUM_SRC = uirq_pkg::UIRQ_NUM_SRC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               w1c_en,
   input  logic [NUM_SRC-1:0] bits,
   output logic [NUM_SRC-1:0] stat_q
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_bit
         logic drop;
         assign drop = w1c_en && bits[gi];
         // A new event outranks a clear in the same cycle.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stat_q[gi] <= 1'b0;
            else if (evt[gi]) stat_q[gi] <= 1'b1;
            else if (drop)    stat_q[gi] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/uirq_irq_out.sv
module uirq_irq_out #(
   parameter int unsigned NUM_SRC = uirq_pkg::UIRQ_NUM_SRC,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] mask_q,
   input  logic [NUM_SRC-1:0] stat_q,
   output logic               irq
);
   logic pend;
   assign pend = |(mask_q & stat_q);

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= pend;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq        = pend;
      end
   endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
   parameter int unsigned NUM_SRC  = uirq_pkg::UIRQ_NUM_SRC,
   parameter int unsigned DATA_W   = uirq_pkg::UIRQ_DATA_W,
   parameter int unsigned ADDR_W   = uirq_pkg::UIRQ_ADDR_W,
   parameter int unsigned OFS_SET  = uirq_pkg::UIRQ_OFS_SET,
   parameter int unsigned OFS_CLR  = uirq_pkg::UIRQ_OFS_CLR,
   parameter int unsigned OFS_MASK = uirq_pkg::UIRQ_OFS_MASK,
   parameter int unsigned OFS_STAT = uirq_pkg::UIRQ_OFS_STAT,
   parameter bit          IRQ_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [12:0]        evt_i,
   input  logic               wr_en,
   input  logic [7:0]         addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               irq_o
);
   // Elaboration-time parameter checks.
   if (NUM_SRC != 13 || DATA_W != 32 || ADDR_W != 8) begin : g_bad_width
      $error("uart_irq_ctrl: port widths fixed at 13/32/8");
   end
   if (NUM_SRC > DATA_W) begin : g_bad_src
      $error("uart_irq_ctrl: NUM_SRC exceeds DATA_W");
   end
   if ((OFS_SET % 4) != 0 || (OFS_CLR % 4) != 0 ||
       (OFS_MASK % 4) != 0 || (OFS_STAT % 4) != 0) begin : g_bad_align
      $error("uart_irq_ctrl: offsets must be word aligned");
   end
   if (OFS_SET == OFS_CLR || OFS_SET == OFS_MASK || OFS_SET == OFS_STAT ||
       OFS_CLR == OFS_MASK || OFS_CLR == OFS_STAT ||
       OFS_MASK == OFS_STAT) begin : g_bad_map
      $error("uart_irq_ctrl: offsets must be distinct");
   end
   if (OFS_STAT >= (1 << ADDR_W)) begin : g_bad_range
      $error("uart_irq_ctrl: offset outside address space");
   end

   uirq_pkg::uirq_wr_t wr_act;
   logic [NUM_SRC-1:0] wr_bits;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] stat_q;

   uirq_regif #(
      .NUM_SRC (NUM_SRC),  .DATA_W (DATA_W),   .ADDR_W (ADDR_W),
      .OFS_SET (OFS_SET),  .OFS_CLR (OFS_CLR),
      .OFS_MASK(OFS_MASK), .OFS_STAT(OFS_STAT)
   ) regif_i (
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .mask_q (mask_q),
      .stat_q (stat_q),
      .wr_act (wr_act),
      .wr_bits(wr_bits),
      .rdata  (rdata)
   );

   uirq_mask_reg #(.NUM_SRC(NUM_SRC)) mask_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(wr_act.set_mask),
      .clr_en(wr_act.clr_mask),
      .bits  (wr_bits),
      .mask_q(mask_q)
   );

   uirq_sticky_stat #(.NUM_SRC(NUM_SRC)) stat_i (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_i),
      .w1c_en(wr_act.clr_stat),
      .bits  (wr_bits),
      .stat_q(stat_q)
   );

   uirq_irq_out #(.NUM_SRC(NUM_SRC), .IRQ_REG(IRQ_REG)) irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .mask_q(mask_q),
      .stat_q(stat_q),
      .irq   (irq_o)
   );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
   parameter int unsigned NUM_SRC  = 13,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned OFS_SET  = 'h08,
   parameter int unsigned OFS_CLR  = 'h0C,
   parameter int unsigned OFS_STAT = 'h14,
   parameter bit          IRQ_REG  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [NUM_SRC-1:0] wr_bits,
   input logic [31:0]        rdata,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] stat_q
);
   localparam logic [ADDR_W-1:0] A_SET  = OFS_SET[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CLR  = OFS_CLR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_STAT = OFS_STAT[ADDR_W-1:0];

   logic               w_set, w_clr, w_stat;
   logic [NUM_SRC-1:0] clr_v;
   logic [NUM_SRC-1:0] clash_v;

   assign w_set   = wr_en && (addr == A_SET);
   assign w_clr   = wr_en && (addr == A_CLR);
   assign w_stat  = wr_en && (addr == A_STAT);
   assign clr_v   = w_stat ? wr_bits : '0;
   assign clash_v = clr_v & evt_i;

   assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> mask_q == ($past(mask_q) | $past(wr_bits)));

   assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> mask_q == ($past(mask_q) & ~$past(wr_bits)));

   assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_set || w_clr) |=> $stable(mask_q));

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat_q) & ~$past(clr_v)) & ~stat_q) == '0);

   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (w_stat && evt_i == '0) |=> (stat_q & $past(wr_bits)) == '0);

   assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|clash_v) |=> (stat_q & $past(clash_v)) == $past(clash_v));

   generate
      if (IRQ_REG) begin : g_irq_chk
         assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq_o == $past(|(stat_q & mask_q)));
      end
   endgenerate

   assert_rd_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata >> NUM_SRC) == 32'd0);

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .ADDR_W  (ADDR_W),
   .OFS_SET (OFS_SET),
   .OFS_CLR (OFS_CLR),
   .OFS_STAT(OFS_STAT),
   .IRQ_REG (IRQ_REG)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .evt_i  (evt_i),
   .wr_en  (wr_en),
   .addr   (addr),
   .wr_bits(wdata[NUM_SRC-1:0]),
   .rdata  (rdata),
   .irq_o  (irq_o),
   .mask_q (mask_q),
   .stat_q (stat_q)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
   localparam logic [7:0] A_SET  = 8'h08;
   localparam logic [7:0] A_CLR  = 8'h0C;
   localparam logic [7:0] A_MASK = 8'h10;
   localparam logic [7:0] A_STAT = 8'h14;
   localparam logic [7:0] A_IDLE = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] evt_i = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = A_IDLE;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [12:0] exp_mask = '0;
   logic [12:0] exp_stat = '0;
   logic        exp_irq  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   uart_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // One clock cycle with the given bus and event inputs; model follows.
   task automatic cyc(input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [12:0] e);
      wr_en = w; addr = a; wdata = d; evt_i = e;
      @(posedge clk);
      exp_irq = |(exp_stat & exp_mask);
      if (w) begin
         if (a == A_SET)  exp_mask = exp_mask | d[12:0];
         if (a == A_CLR)  exp_mask = exp_mask & ~d[12:0];
         if (a == A_STAT) exp_stat = exp_stat & ~d[12:0];
      end
      exp_stat = exp_stat | e;
      #1;
      wr_en = 1'b0; addr = A_IDLE; wdata = '0; evt_i = '0;
      check("R8 irq", {31'd0, irq_o}, {31'd0, exp_irq});
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a,
                         input logic [31:0] exp);
      addr = a;
      #0.5;
      check(req, rdata, exp);
      addr = A_IDLE;
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      rd_chk("R1 mask", A_MASK, 32'd0);
      rd_chk("R1 stat", A_STAT, 32'd0);
      check("R1 irq", {31'd0, irq_o}, 32'd0);
      rst_n = 1'b1;
      cyc(1'b0, A_IDLE, 0, '0);

      // Per-source sweep: enable, event, hold, clear, disable.
      for (int i = 0; i < 13; i++) begin
         cyc(1'b1, A_SET, 32'd1 << i, '0);
         rd_chk("R2 mask set", A_MASK, {19'd0, exp_mask});
         cyc(1'b0, A_IDLE, 0, 13'd1 << i);               // R5 event
         rd_chk("R5 stat set", A_STAT, {19'd0, exp_stat});
         cyc(1'b0, A_IDLE, 0, '0);                       // R8 irq rises here
         check("R8 irq up", {31'd0, irq_o}, 32'd1);
         cyc(1'b0, A_IDLE, 0, '0);
         rd_chk("R5 sticky", A_STAT, 32'd1 << i);
         cyc(1'b1, A_STAT, 32'd1 << i, '0);
         rd_chk("R6 clear", A_STAT, 32'd0);
         cyc(1'b0, A_IDLE, 0, '0);
         check("R8 irq down", {31'd0, irq_o}, 32'd0);
         cyc(1'b1, A_CLR, 32'd1 << i, '0);
         rd_chk("R3 mask clr", A_MASK, 32'd0);
         // Masked-off event must not raise irq (R8)
         cyc(1'b0, A_IDLE, 0, 13'd1 << i);
         cyc(1'b0, A_IDLE, 0, '0);
         check("R8 masked", {31'd0, irq_o}, 32'd0);
         cyc(1'b1, A_STAT, 32'h1FFF, '0);
      end

      // Multi-bit set/clear patterns (R2, R3)
      cyc(1'b1, A_SET, 32'h1FFF, '0);
      cyc(1'b1, A_CLR, 32'h0AAA, '0);
      rd_chk("R3 pattern", A_MASK, 32'h1555);
      cyc(1'b1, A_SET, 32'h0002, '0);
      rd_chk("R2 pattern", A_MASK, 32'h1557);

      // Writes to mask readback and other addresses are ignored (R4)
      cyc(1'b1, A_MASK, 32'h0000, '0);
      rd_chk("R4 mask wr", A_MASK, 32'h1557);
      cyc(1'b1, A_STAT, 32'h1FFF, '0);
      rd_chk("R4 stat wr", A_MASK, 32'h1557);
      cyc(1'b1, 8'h30, 32'h1FFF, '0);
      rd_chk("R4 other wr", A_MASK, 32'h1557);

      // Partial and full clear (R6)
      cyc(1'b0, A_IDLE, 0, 13'h1FFF);
      cyc(1'b1, A_STAT, 32'h00F0, '0);
      rd_chk("R6 partial", A_STAT, 32'h1F0F);
      cyc(1'b1, A_STAT, 32'h1FFF, '0);
      rd_chk("R6 all", A_STAT, 32'h0000);

      // Event and clear in the same cycle (R7)
      cyc(1'b1, A_STAT, 32'h1FFF, 13'h0008);
      rd_chk("R7 tx empty kept", A_STAT, 32'h0008);
      cyc(1'b0, A_IDLE, 0, 13'h1001);
      cyc(1'b1, A_STAT, 32'h1001, 13'h0001);
      rd_chk("R7 mixed", A_STAT, 32'h0009);
      cyc(1'b1, A_STAT, 32'h1FFF, '0);

      // Upper bits and unmapped reads (R9)
      cyc(1'b1, A_CLR, 32'hFFFF_E000, '0);
      rd_chk("R9 hi clr ignored", A_MASK, 32'h1557);
      cyc(1'b1, A_SET, 32'hFFFF_E000, '0);
      rd_chk("R9 hi set ignored", A_MASK, 32'h1557);
      rd_chk("R9 read set addr", A_SET, 32'd0);
      rd_chk("R9 read clr addr", A_CLR, 32'd0);
      rd_chk("R9 read unmapped", 8'h30, 32'd0);
      cyc(1'b0, A_IDLE, 0, 13'h1FFF);
      rd_chk("R9 stat hi zero", A_STAT, 32'h1FFF);

      // Sweep status clear patterns with all bits set (R6, R8)
      for (int p = 0; p < 32; p++) begin
         logic [12:0] pat;
         pat = 13'((p * 397) ^ (p << 7));
         cyc(1'b0, A_IDLE, 0, 13'h1FFF);
         cyc(1'b1, A_STAT, {19'd0, pat}, '0);
         rd_chk("R6 sweep", A_STAT, {19'd0, 13'h1FFF & ~pat});
         cyc(1'b0, A_IDLE, 0, '0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule